// File: doc/BRIEF.md
# Banked Display Window Address Mapper

This block sits between a host bus and a video memory. The host sees display memory through a 64 KB window. The block extends each host offset into a 20-bit linear video memory address by putting a 4-bit bank number above it. The bank number comes from a small set of control registers. Software programs those registers through an indexed extended-register port and through the miscellaneous output register.

The block is built in one of two variants, selected by a parameter.

- **Unified variant.** One bank number serves both reads and writes. Its lowest bit is held in the miscellaneous output register and its upper three bits in the segment register.
- **Split variant.** The segment register holds two independent banks, one for reads and one for writes.

Bank mapping is gated by an enhanced-mode bit. Writes to the extended registers are gated by an unlock bit in the master register. The master register also reports, read-only, which variant was built.

Top module: `bankmap_top`

## Requirements
- R1: After a synchronous reset, every stored register is zero. While the block is in that state, `mem_addr` equals `{4'h0, host_addr}` and `ext_rdata` reads 0 at indices 0Ch and 0Dh.
- R2: Writes to index 0Ch (mode) and index 0Dh (segment) are ignored unless bit 5 of index 0Fh (master) is 1. A write to index 0Fh is always accepted, and it stores bits 7:4 of the written data.
- R3: Bits 3:0 read at index 0Fh are read-only. They return 0 for the unified variant and 1 for the split variant. Bits 7:4 return the stored master bits.
- R4: A write on the miscellaneous output port stores all 8 bits. The stored value appears on `misc_rdata` from the next cycle on.
- R5: While bit 5 of index 0Ch (enhanced mode) is 0, the bank is 0 and `mem_addr[19:16]` is 0.
- R6: In the unified variant with enhanced mode on, the bank is `{seg[2:0], misc[5]}`. The same bank is used for reads and writes.
- R7: In the split variant with enhanced mode on, `seg[3:0]` is the bank for a host read and `seg[7:4]` is the bank for a host write. A write takes priority when both strobes are high. The read bank applies when no strobe is high.
- R8: Reading index 0Dh returns exactly the last 8-bit value accepted into it, in both variants. Reading index 0Ch returns its stored value, and any other index reads 0.
- R9: `mem_addr` is `{bank, host_addr}`, and `mem_req` is high exactly when `host_rd` or `host_wr` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 16 | Host offset inside the display window |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| misc_wr | input | 1 | Write strobe for the miscellaneous output register |
| misc_wdata | input | 8 | Data for the miscellaneous output register |
| misc_rdata | output | 8 | Readback of the miscellaneous output register |
| ext_wr | input | 1 | Extended register write strobe |
| ext_widx | input | 8 | Extended register write index |
| ext_wdata | input | 8 | Extended register write data |
| ext_ridx | input | 8 | Extended register read index |
| ext_rdata | output | 8 | Extended register read data |
| mem_addr | output | 20 | Linear video memory address |
| mem_req | output | 1 | Host access in progress |

## Verification
Both variants are instantiated side by side and driven by the same stimulus.

- **Host strobes.** Reads, writes, both strobes together and no strobe are each applied. In the split variant these reveal whether the read nibble or the write nibble was chosen. In the unified variant they must give the same bank every time.
- **Segment patterns.** The segment values use different read and write nibbles, such as A5h and 3Ch. This exposes swapped nibbles. Toggling misc bit 5 alone separates the unified variant's low bank bit from the segment bits.
- **Gate bits.** Writes are tried before and after the unlock bit is set, and with enhanced mode off and on. These show whether each gate works on its own.

// File: rtl/bankmap_pkg.sv
package bankmap_pkg;

    typedef enum logic {
        BANK_UNIFIED = 1'b0,
        BANK_SPLIT   = 1'b1
    } bank_mode_e;

    localparam int BANK_W    = 4;
    localparam int REG_W     = 8;
    localparam int MISC_BANK = 5;   // bank bit 0 in unified variant
    localparam int ENH_BIT   = 5;   // enhanced mode in mode register
    localparam int UNLK_BIT  = 1;   // bit 5 of master == bit 1 of stored upper nibble

    localparam logic [REG_W-1:0] IDX_MODE   = 8'h0C;
    localparam logic [REG_W-1:0] IDX_SEG    = 8'h0D;
    localparam logic [REG_W-1:0] IDX_MASTER = 8'h0F;

    typedef struct packed {
        logic [REG_W-1:0]   misc;
        logic [REG_W-1:0]   mode;
        logic [REG_W-1:0]   seg;
        logic [REG_W/2-1:0] master_hi;
    } bank_regs_t;

    function automatic logic [REG_W/2-1:0] variant_id(bank_mode_e m);
        return (m == BANK_SPLIT) ? 4'd1 : 4'd0;
    endfunction

endpackage

// File: rtl/bankmap_regs.sv
module bankmap_regs
    import bankmap_pkg::*;
#(
    parameter bank_mode_e MODE = BANK_SPLIT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             misc_wr,
    input  logic [REG_W-1:0] misc_wdata,
    input  logic             ext_wr,
    input  logic [REG_W-1:0] ext_widx,
    input  logic [REG_W-1:0] ext_wdata,
    input  logic [REG_W-1:0] ext_ridx,
    output logic [REG_W-1:0] ext_rdata,
    output logic [REG_W-1:0] misc_rdata,
    output bank_regs_t       regs
);

    logic unlocked;
    assign unlocked = regs.master_hi[UNLK_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else begin
            if (misc_wr)
                regs.misc <= misc_wdata;
            if (ext_wr) begin
                if (ext_widx == IDX_MASTER)
                    regs.master_hi <= ext_wdata[REG_W-1:REG_W/2];
                else if (unlocked && ext_widx == IDX_MODE)
                    regs.mode <= ext_wdata;
                else if (unlocked && ext_widx == IDX_SEG)
                    regs.seg <= ext_wdata;
            end
        end
    end

    always_comb begin
        unique case (ext_ridx)
            IDX_MODE:   ext_rdata = regs.mode;
            IDX_SEG:    ext_rdata = regs.seg;
            IDX_MASTER: ext_rdata = {regs.master_hi, variant_id(MODE)};
            default:    ext_rdata = '0;
        endcase
    end

    assign misc_rdata = regs.misc;

    // R2: locked writes leave mode and segment untouched
    assert_locked_write_R2: assert property (@(posedge clk) disable iff (rst)
        (ext_wr && !unlocked && ext_widx != IDX_MASTER)
        |=> ($stable(regs.seg) && $stable(regs.mode)));

    // R3: variant nibble is fixed
    assert_variant_id_R3: assert property (@(posedge clk) disable iff (rst)
        (ext_ridx == IDX_MASTER) |-> (ext_rdata[3:0] == ((MODE == BANK_SPLIT) ? 4'd1 : 4'd0)));

    // R4: misc readback follows the write one cycle later
    assert_misc_readback_R4: assert property (@(posedge clk) disable iff (rst)
        misc_wr |=> (misc_rdata == $past(misc_wdata)));

    // R8: accepted segment write reads back unchanged
    assert_seg_readback_R8: assert property (@(posedge clk) disable iff (rst)
        (ext_wr && unlocked && ext_widx == IDX_SEG && ext_ridx == IDX_SEG)
        |=> (ext_rdata == $past(ext_wdata)));

endmodule

// File: rtl/bankmap_select.sv
module bankmap_select
    import bankmap_pkg::*;
#(
    parameter bank_mode_e MODE = BANK_SPLIT
) (
    input  logic              clk,
    input  logic              rst,
    input  bank_regs_t        regs,
    input  logic              host_wr,
    output logic [BANK_W-1:0] bank
);

    logic              enh;
    logic [BANK_W-1:0] raw_bank;

    assign enh = regs.mode[ENH_BIT];

    generate
        if (MODE == BANK_SPLIT) begin : g_split
            always_comb begin
                if (host_wr)
                    raw_bank = regs.seg[2*BANK_W-1:BANK_W];
                else
                    raw_bank = regs.seg[BANK_W-1:0];
            end
        end else begin : g_unified
            always_comb begin
                raw_bank = {regs.seg[BANK_W-2:0], regs.misc[MISC_BANK]};
            end
        end
    endgenerate

    assign bank = enh ? raw_bank : '0;

    // R5: no enhanced mode, no bank
    assert_bank_zero_R5: assert property (@(posedge clk) disable iff (rst)
        !regs.mode[ENH_BIT] |-> (bank == '0));

    // R7: split variant picks a nibble of the segment register
    generate
        if (MODE == BANK_SPLIT) begin : g_chk_split
            assert_split_nibble_R7: assert property (@(posedge clk) disable iff (rst)
                regs.mode[ENH_BIT] |->
                ((bank == regs.seg[7:4]) || (bank == regs.seg[3:0])));
        end else begin : g_chk_unified
            assert_unified_lsb_R6: assert property (@(posedge clk) disable iff (rst)
                regs.mode[ENH_BIT] |-> (bank[0] == regs.misc[MISC_BANK]));
        end
    endgenerate

endmodule

// File: rtl/bankmap_addr.sv
module bankmap_addr
    import bankmap_pkg::*;
#(
    parameter int HOST_AW = 16,
    localparam int MEM_AW = HOST_AW + BANK_W
) (
    input  logic [BANK_W-1:0]  bank,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic               host_rd,
    input  logic               host_wr,
    output logic [MEM_AW-1:0]  mem_addr,
    output logic               mem_req
);

    assign mem_addr = {bank, host_addr};
    assign mem_req  = host_rd | host_wr;

endmodule

// File: rtl/bankmap_top.sv
module bankmap_top
    import bankmap_pkg::*;
#(
    parameter bank_mode_e MODE    = BANK_SPLIT,
    parameter int         HOST_AW = 16,
    localparam int        MEM_AW  = HOST_AW + BANK_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic               host_rd,
    input  logic               host_wr,
    input  logic               misc_wr,
    input  logic [REG_W-1:0]   misc_wdata,
    output logic [REG_W-1:0]   misc_rdata,
    input  logic               ext_wr,
    input  logic [REG_W-1:0]   ext_widx,
    input  logic [REG_W-1:0]   ext_wdata,
    input  logic [REG_W-1:0]   ext_ridx,
    output logic [REG_W-1:0]   ext_rdata,
    output logic [MEM_AW-1:0]  mem_addr,
    output logic               mem_req
);

    bank_regs_t        regs;
    logic [BANK_W-1:0] bank;

    bankmap_regs #(.MODE(MODE)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .misc_wr    (misc_wr),
        .misc_wdata (misc_wdata),
        .ext_wr     (ext_wr),
        .ext_widx   (ext_widx),
        .ext_wdata  (ext_wdata),
        .ext_ridx   (ext_ridx),
        .ext_rdata  (ext_rdata),
        .misc_rdata (misc_rdata),
        .regs       (regs)
    );

    bankmap_select #(.MODE(MODE)) u_select (
        .clk     (clk),
        .rst     (rst),
        .regs    (regs),
        .host_wr (host_wr),
        .bank    (bank)
    );

    bankmap_addr #(.HOST_AW(HOST_AW)) u_addr (
        .bank      (bank),
        .host_addr (host_addr),
        .host_rd   (host_rd),
        .host_wr   (host_wr),
        .mem_addr  (mem_addr),
        .mem_req   (mem_req)
    );

    // R9: low address bits pass the host offset through
    assert_offset_pass_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_addr[HOST_AW-1:0] == host_addr) && (mem_req == (host_rd || host_wr)));

endmodule

// File: tb/bankmap_top_test.sv
module bankmap_top_test;
    import bankmap_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] host_addr = '0;
    logic        host_rd = 1'b0, host_wr = 1'b0;
    logic        misc_wr = 1'b0;
    logic [7:0]  misc_wdata = '0;
    logic        ext_wr = 1'b0;
    logic [7:0]  ext_widx = '0, ext_wdata = '0, ext_ridx = '0;

    logic [7:0]  misc_rd_u, misc_rd_s, ext_rd_u, ext_rd_s;
    logic [19:0] addr_u, addr_s;
    logic        req_u, req_s;

    int checks = 0;
    int fails  = 0;
    string tag = "R1";

    always #2.5 clk = ~clk;

    bankmap_top #(.MODE(BANK_UNIFIED)) uut (
        .clk(clk), .rst(rst), .host_addr(host_addr), .host_rd(host_rd), .host_wr(host_wr),
        .misc_wr(misc_wr), .misc_wdata(misc_wdata), .misc_rdata(misc_rd_u),
        .ext_wr(ext_wr), .ext_widx(ext_widx), .ext_wdata(ext_wdata), .ext_ridx(ext_ridx),
        .ext_rdata(ext_rd_u), .mem_addr(addr_u), .mem_req(req_u));

    bankmap_top #(.MODE(BANK_SPLIT)) uut_split (
        .clk(clk), .rst(rst), .host_addr(host_addr), .host_rd(host_rd), .host_wr(host_wr),
        .misc_wr(misc_wr), .misc_wdata(misc_wdata), .misc_rdata(misc_rd_s),
        .ext_wr(ext_wr), .ext_widx(ext_widx), .ext_wdata(ext_wdata), .ext_ridx(ext_ridx),
        .ext_rdata(ext_rd_s), .mem_addr(addr_s), .mem_req(req_s));

    // behavioural reference state
    int m_misc = 0, m_mode = 0, m_seg = 0, m_master = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_misc <= 0; m_mode <= 0; m_seg <= 0; m_master <= 0;
        end else begin
            if (misc_wr) m_misc <= int'(misc_wdata);
            if (ext_wr) begin
                if (ext_widx == 8'h0F)
                    m_master <= int'(ext_wdata) & 'hF0;
                else if ((m_master & 'h20) != 0) begin
                    if (ext_widx == 8'h0C) m_mode <= int'(ext_wdata);
                    if (ext_widx == 8'h0D) m_seg  <= int'(ext_wdata);
                end
            end
        end
    end

    function automatic int exp_addr(bit split);
        int b;
        if ((m_mode & 'h20) == 0) b = 0;
        else if (!split) b = ((m_seg & 7) * 2) + ((m_misc / 32) % 2);
        else if (host_wr) b = (m_seg / 16) % 16;
        else b = m_seg % 16;
        return b * 65536 + int'(host_addr);
    endfunction

    function automatic int exp_rdata(bit split);
        if (ext_ridx == 8'h0C) return m_mode;
        if (ext_ridx == 8'h0D) return m_seg;
        if (ext_ridx == 8'h0F) return m_master + (split ? 1 : 0);
        return 0;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // compared on every clock at the falling edge
    always @(negedge clk) begin
        if (!rst) begin
            check({tag, " unified addr"}, int'(addr_u), exp_addr(1'b0));
            check({tag, " split addr"},   int'(addr_s), exp_addr(1'b1));
            check({tag, " unified rdata"}, int'(ext_rd_u), exp_rdata(1'b0));
            check({tag, " split rdata"},   int'(ext_rd_s), exp_rdata(1'b1));
            check({tag, " misc"}, int'(misc_rd_u), m_misc);
            check({tag, " req R9"}, int'(req_s), int'(host_rd | host_wr));
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic ext_write(logic [7:0] idx, logic [7:0] d);
        ext_wr = 1'b1; ext_widx = idx; ext_wdata = d;
        step();
        ext_wr = 1'b0;
    endtask

    task automatic misc_write(logic [7:0] d);
        misc_wr = 1'b1; misc_wdata = d;
        step();
        misc_wr = 1'b0;
    endtask

    task automatic host(logic rd, logic wr, logic [15:0] a);
        host_rd = rd; host_wr = wr; host_addr = a;
        step();
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        // R1 reset state
        tag = "R1";
        host(1'b1, 1'b0, 16'h1234);
        check("R1 reset addr", int'(addr_s), 'h01234);
        ext_ridx = 8'h0D; step();
        check("R1 reset seg", int'(ext_rd_u), 0);

        // R2 locked writes ignored
        tag = "R2";
        ext_write(8'h0D, 8'hA5);
        ext_write(8'h0C, 8'h20);
        ext_ridx = 8'h0D; step();
        check("R2 locked seg", int'(ext_rd_s), 0);
        ext_ridx = 8'h0C; step();
        check("R2 locked mode", int'(ext_rd_s), 0);

        // R3 master readback
        tag = "R3";
        ext_write(8'h0F, 8'h2F);
        ext_ridx = 8'h0F; step();
        check("R3 unified id", int'(ext_rd_u), 'h20);
        check("R3 split id", int'(ext_rd_s), 'h21);

        // R8 segment readback, enhanced still off (R5)
        tag = "R8";
        ext_write(8'h0D, 8'hA5);
        ext_ridx = 8'h0D; step();
        check("R8 seg readback unified", int'(ext_rd_u), 'hA5);
        tag = "R5";
        host(1'b0, 1'b1, 16'hBEEF);
        check("R5 enh off", int'(addr_s), 'h0BEEF);

        // R4 misc readback, bank bit 0 source
        tag = "R4";
        misc_write(8'h20);
        check("R4 misc", int'(misc_rd_s), 'h20);

        // enable enhanced mode
        tag = "R6";
        ext_write(8'h0C, 8'h20);
        host(1'b1, 1'b0, 16'h0010);
        check("R6 unified bank", int'(addr_u), 'hB0010);
        host(1'b0, 1'b1, 16'h0010);
        check("R6 unified write same bank", int'(addr_u), 'hB0010);
        misc_write(8'h00);
        check("R6 misc bit cleared", int'(addr_u), 'hA0010);

        tag = "R7";
        host(1'b1, 1'b0, 16'h4000);
        check("R7 read bank", int'(addr_s), 'h54000);
        host(1'b0, 1'b1, 16'h4000);
        check("R7 write bank", int'(addr_s), 'hA4000);
        host(1'b1, 1'b1, 16'h4000);
        check("R7 both strobes write wins", int'(addr_s), 'hA4000);
        host(1'b0, 1'b0, 16'h4000);
        check("R7 idle uses read bank", int'(addr_s), 'h54000);
        check("R9 idle req", int'(req_s), 0);

        ext_write(8'h0D, 8'h3C);
        for (int i = 0; i < 16; i++) host(i[0], i[1], 16'(i * 4099));

        // relock then try writes
        tag = "R2";
        ext_write(8'h0F, 8'h00);
        ext_write(8'h0D, 8'hFF);
        ext_ridx = 8'h0D; step();
        check("R2 relocked seg kept", int'(ext_rd_s), 'h3C);

        tag = "R5";
        ext_write(8'h0F, 8'h20);
        ext_write(8'h0C, 8'h00);
        host(1'b0, 1'b1, 16'hFFFF);
        check("R5 enh off again", int'(addr_u), 'h0FFFF);

        tag = "R8";
        ext_ridx = 8'h33; step();
        check("R8 unknown index", int'(ext_rd_s), 0);

        step();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule